// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block produces a one-cycle pixel enable from a reference clock. A host writes a single configuration word. The word holds a bypass flag and a divisor that is split into a low field and a high field at separate bit positions. Without bypass, the enable fires once every (divisor + 2) reference cycles. With bypass set, the enable is high on every cycle and the divisor is not used. A ratio of one is only reachable through the bypass flag.

The host can read the word back to recover the current rate. Readback returns the stored flag and divisor bits and reads every other bit as zero. A new setting is held in the stored word until the running period ends, and only then becomes active. A change of ratio therefore never cuts a period short and never produces an extra pulse.

Top module: `pixclk_div`

## Requirements
- R1: After reset the readback word is zero and the block runs at ratio 2: the enable is low in the first cycle after reset is released and high in the second.
- R2: Configuration word layout: bit 26 is the bypass flag, bits 4:0 are the low divisor field, and bits 31:27 are the high divisor field. The divisor is {high, low}, a 10-bit value. Every other bit is dropped on write and reads as zero.
- R3: With bypass clear, the enable is high for exactly one cycle in every (divisor + 2) cycles.
- R4: With bypass active, the enable is high on every cycle, whatever the divisor fields hold.
- R5: The cycle after a write, readback returns the written flag and divisor bits unchanged.
- R6: A write does not change the running period. The stored setting becomes active at the next enable pulse, and the new period starts in the cycle after that pulse. If several writes fall within one period, the last one applies.
- R7: The divisor extremes give ratio 2 for divisor 0 and ratio 1025 for divisor 1023.
- R8: While bypass is not active, the enable is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the configuration word |
| regWrData | input | 32 | Configuration word to store |
| regRdData | output | 32 | Stored configuration word; unused bits read as zero |
| pixEn | output | 1 | Pixel clock enable, one reference cycle wide |

## Verification
The hardest case to reach is a write that lands partway through a long period. The old ratio must finish exactly before the new one takes over. Bypass adds a second hard case: entering bypass gives back-to-back pulses, and leaving it must restart the count from zero. The stimulus builds these cases directly. It writes mid-period, issues two writes within one period, and moves into and out of bypass with different divisors loaded. It also runs a full 1025-cycle period twice. A behavioural model tracks the pending and active settings and checks the enable and the readback on every clock.

// File: rtl/pixclk_div_pkg.sv
package pixclk_div_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic loadCfg;   // copy stored setting into the active setting
    logic clearCnt;  // restart the divide count
    logic incCnt;    // advance the divide count
  } divStrobe_t;
endpackage

// File: rtl/pixclk_div_dp.sv
module pixclk_div_dp
  import pixclk_div_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int LO_POS  = 0,
  parameter int LO_W    = 5,
  parameter int HI_POS  = 27,
  parameter int HI_W    = 5,
  parameter int BYP_POS = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  divStrobe_t       strobe,
  output logic             actBypass,
  output logic             atTerminal
);
  localparam int DIV_W = LO_W + HI_W;
  localparam int CNT_W = DIV_W + 1;

  logic [LO_W-1:0]  storedLo;
  logic [HI_W-1:0]  storedHi;
  logic             storedByp;
  logic [DIV_W-1:0] storedDiv;
  logic [DIV_W-1:0] actDiv;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // host-visible storage: written at once, active copy taken at wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedLo  <= '0;
      storedHi  <= '0;
      storedByp <= 1'b0;
    end else if (regWrEn) begin
      storedLo  <= regWrData[LO_POS +: LO_W];
      storedHi  <= regWrData[HI_POS +: HI_W];
      storedByp <= regWrData[BYP_POS];
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[LO_POS +: LO_W] = storedLo;
    regRdData[HI_POS +: HI_W] = storedHi;
    regRdData[BYP_POS]        = storedByp;
  end

  assign storedDiv = {storedHi, storedLo};

  // active setting and divide count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actBypass <= 1'b0;
      actDiv    <= '0;
    end else if (strobe.loadCfg) begin
      actBypass <= storedByp;
      actDiv    <= storedDiv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.clearCnt) cnt <= '0;
    else if (strobe.incCnt)   cnt <= cnt + CNT_W'(1);
  end

  assign limit      = {1'b0, actDiv} + CNT_W'(1);
  assign atTerminal = (cnt == limit);

  // R3: the count never runs past the terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit);

  // R6: the active divisor only changes after a load strobe
  p_cfg_at_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actDiv) |-> $past(strobe.loadCfg));

  // R8: loading a non-bypass setting never reaches terminal at once
  p_no_unit_ratio_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCfg && !storedByp) |=> !atTerminal);

  // R5: readback carries the written flag and fields
  p_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData[BYP_POS] == $past(regWrData[BYP_POS])) &&
                (regRdData[LO_POS +: LO_W] == $past(regWrData[LO_POS +: LO_W])) &&
                (regRdData[HI_POS +: HI_W] == $past(regWrData[HI_POS +: HI_W])));
endmodule

// File: rtl/pixclk_div_ctrl.sv
module pixclk_div_ctrl
  import pixclk_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actBypass,
  input  logic       atTerminal,
  output divStrobe_t strobe,
  output logic       pixEn
);
  logic wrap;

  // a period ends on terminal count, or every cycle in bypass
  assign wrap = actBypass || atTerminal;

  always_comb begin
    strobe.loadCfg  = wrap;
    strobe.clearCnt = wrap;
    strobe.incCnt   = !wrap;
  end

  assign pixEn = wrap;

  // R8: outside bypass a pulse is followed by a quiet cycle
  p_pulse_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && !actBypass) |=> (!pixEn || actBypass));
endmodule

// File: rtl/pixclk_div.sv
module pixclk_div
  import pixclk_div_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int LO_POS  = 0,
  parameter int LO_W    = 5,
  parameter int HI_POS  = 27,
  parameter int HI_W    = 5,
  parameter int BYP_POS = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             pixEn
);
  divStrobe_t strobe;
  logic       actBypass;
  logic       atTerminal;

  pixclk_div_dp #(
    .REG_W(REG_W), .LO_POS(LO_POS), .LO_W(LO_W),
    .HI_POS(HI_POS), .HI_W(HI_W), .BYP_POS(BYP_POS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .actBypass(actBypass), .atTerminal(atTerminal)
  );

  pixclk_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .actBypass(actBypass), .atTerminal(atTerminal),
    .strobe(strobe), .pixEn(pixEn)
  );
endmodule

// File: tb/pixclk_div_test.sv
`timescale 1ns/1ps
module pixclk_div_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pixEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural model state
  int mByp, mDiv, aByp, aRatio, ph;
  int prevPix;

  pixclk_div uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pixEn(pixEn)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(input int byp, input int dv);
    logic [31:0] w;
    w = '0;
    w[26]    = byp[0];
    w[4:0]   = dv[4:0];
    w[31:27] = dv[9:5];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h (cycle %0d)", req, got, exp, cycles);
    end
  endtask

  task automatic step(input bit we, input logic [31:0] d);
    int wrap;
    int expPix;
    regWrEn   = we;
    regWrData = d;
    @(posedge clk);
    wrap = (aByp != 0 || ph == aRatio - 1) ? 1 : 0;
    if (wrap != 0) begin
      aByp = mByp; aRatio = mDiv + 2; ph = 0;
    end else ph++;
    if (we) begin
      mByp = d[26];
      mDiv = int'({d[31:27], d[4:0]});
    end
    @(negedge clk);
    regWrEn = 1'b0;
    expPix = (aByp != 0 || ph == aRatio - 1) ? 1 : 0;
    chk(curReq, 32'(pixEn), 32'(expPix));
    chk("R5", regRdData, mk(mByp, mDiv));
    if (prevPix != 0 && aByp == 0) chk("R8", 32'(pixEn), 32'd0);
    prevPix = pixEn;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  task automatic wr(input int byp, input int dv);
    step(1'b1, mk(byp, dv));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    mByp = 0; mDiv = 0; aByp = 0; aRatio = 2; ph = 0; prevPix = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1: reset state
    chk("R1", regRdData, 32'h0);
    chk("R1", 32'(pixEn), 32'd0);
    curReq = "R1";
    run(6);

    // R2: field positions, unused bits dropped
    curReq = "R2";
    step(1'b1, 32'h7BFF_FFE3);
    chk("R2", regRdData, 32'h7800_0003);
    curReq = "R3";
    run(1000);

    // R3: a range of small ratios, low and high fields
    wr(0, 1);  run(30);
    wr(0, 2);  run(30);
    wr(0, 5);  run(40);
    wr(0, 32); run(80);
    wr(0, 33); run(80);

    // R4: bypass ignores divisor, then leave bypass
    curReq = "R4";
    wr(1, 7);    run(20);
    wr(1, 1023); run(10);
    wr(0, 3);    run(20);
    wr(1, 0);    run(5);

    // R6: mid-period writes, last one wins
    curReq = "R6";
    wr(0, 9); run(15);
    wr(0, 2); run(2);
    wr(0, 4); run(3);
    wr(0, 6); run(40);
    wr(1, 0); run(3);
    wr(0, 20); run(8);
    wr(0, 1);  run(30);

    // R7: extreme divisors
    curReq = "R7";
    wr(0, 1023); run(2200);
    wr(0, 0);    run(20);
    wr(1, 0);    run(3);
    wr(0, 0);    run(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule